// File: doc/BRIEF.md
# MMU Maintenance Command Controller

This controller sits between a software register port and the translation and cache arrays of a processor's memory management unit. It keeps a 4-bit enable word that switches the instruction TLB, data TLB, instruction cache and data cache on or off independently. It also turns writes to a set of command offsets into maintenance operations on one side, instruction or data. The operations are: a full cache flush, invalidation of a single TLB entry, and invalidation or prefetch of a single cache line.

Line invalidate and line prefetch commands carry a virtual address. The controller therefore runs them in two steps. It first asks the side's TLB for a translation, then hands the resulting physical address to the side's cache. If the TLB on that side is off, the virtual address is used unchanged. If the cache is off, the command retires without any request. A failed translation skips the cache step and sets a sticky error flag, which a status read clears. Each step uses a request/acknowledge pair. A busy flag covers the whole command, and the register port stalls new writes until the command has retired.

Register offsets (4-bit word offsets): 0 is the enable word, 1 is status. Commands sit at offsets 8 to 15, where bit 2 selects the side (1 = instruction, 0 = data) and bits 1:0 select the operation: 0 = TLB entry invalidate, 1 = cache flush, 2 = line invalidate, 3 = line prefetch.

Top module: `mmu_maint_ctrl`

## Requirements
- R1: After reset the enable word is 0, busy is 0, wr_ready is 1, the error flag is clear and no TLB or cache request is raised.
- R2: A write to offset 0 stores wr_data[3:0] into the enable word (bit 3 instruction TLB, bit 2 data TLB, bit 1 instruction cache, bit 0 data cache). The word appears on mode_o and reads back at offset 0 with upper bits zero. All 16 values are accepted.
- R3: Reads of the command offsets 8 to 15 return 0.
- R4: A flush command raises a cache request with cache_op = 1 on its own side only and no TLB request. The written data has no effect on the outcome.
- R5: A TLB invalidate command always raises a TLB request with tlb_op = 1 and the written address on its own side, even when that TLB is disabled, and never raises a cache request.
- R6: A line invalidate (cache_op = 2) or prefetch (cache_op = 3) with the side's TLB enabled first raises a translate request (tlb_op = 0) carrying the virtual address. After the acknowledge, and without a fault, it raises a cache request carrying the returned physical address.
- R7: With the side's TLB disabled, a line invalidate or prefetch raises no TLB request, and the cache request carries the written virtual address unchanged.
- R8: A line or flush command aimed at a disabled cache raises no request and holds busy for exactly one cycle.
- R9: A translation fault during a line invalidate or prefetch suppresses the cache step and sets the error flag. The flag reads as status bit 0 (bit 1 is busy), and a status read clears it.
- R10: busy rises the cycle after a command is accepted and stays high until the command retires. While busy, wr_ready is low, writes are held off and the enable word does not change. Each request stays high until acknowledged.
- R11: Instruction-side commands (offset bit 2 = 1) act only on the instruction-side TLB and cache, and data-side commands act only on the data-side units. At most one request is raised at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Register write strobe |
| wr_ready | output | 1 | Write accepted when high with wr_valid |
| wr_offset | input | OFS_W | Register word offset for the write |
| wr_data | input | AW | Write data or virtual address |
| rd_en | input | 1 | Register read strobe |
| rd_offset | input | OFS_W | Register word offset for the read |
| rd_data | output | AW | Read data (combinational) |
| mode_o | output | 4 | Enable word |
| busy | output | 1 | Command in progress |
| tlb_req | output | 2 | TLB request per side (bit 1 instruction, bit 0 data) |
| tlb_op | output | 2 | Per side: 0 translate, 1 invalidate entry |
| tlb_vaddr | output | 2*AW | Virtual address per side, side s in bits s*AW upward |
| tlb_ack | input | 2 | TLB acknowledge per side |
| tlb_paddr | input | 2*AW | Translated address per side, valid with tlb_ack |
| tlb_fault | input | 2 | Translation miss/fault per side, valid with tlb_ack |
| cache_req | output | 2 | Cache request per side |
| cache_op | output | 4 | Two bits per side: 1 flush, 2 line invalidate, 3 prefetch |
| cache_addr | output | 2*AW | Physical line address per side |
| cache_ack | input | 2 | Cache acknowledge per side |

## Verification
The bench builds the controller with its default 32-bit address and 4-bit offset. Its TLB and cache responders acknowledge after a two-cycle delay, so every request is held across several cycles before the acknowledge arrives. The responders translate by flipping fixed upper address bits and report a fault for addresses whose top nibble is all ones. This makes the translated address distinguishable from the virtual one and lets the fault path be triggered at will. Sweeping the enable word across all-on, TLB-off, cache-off and all-off values brings every branch of the sequencer into reach on both sides.

// File: rtl/mmu_maint_pkg.sv
package mmu_maint_pkg;

    localparam int MODE_W     = 4;
    localparam int N_SIDES    = 2;
    localparam int OFS_MODE   = 0;
    localparam int OFS_STATUS = 1;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_TRANSLATE = 2'd1,
        ST_CACHE_OP  = 2'd2,
        ST_DONE      = 2'd3
    } seq_state_e;

    // Command kind equals the cache opcode for the three cache commands
    typedef enum logic [1:0] {
        CMD_TLB_INV  = 2'd0,
        CMD_FLUSH    = 2'd1,
        CMD_LINE_INV = 2'd2,
        CMD_PREFETCH = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        logic itlb;
        logic dtlb;
        logic icache;
        logic dcache;
    } mode_t;

    typedef struct packed {
        logic      side;   // 1 instruction, 0 data
        cmd_kind_e kind;
    } cmd_t;

    function automatic logic tlb_on(mode_t m, logic side);
        return side ? m.itlb : m.dtlb;
    endfunction

    function automatic logic cache_on(mode_t m, logic side);
        return side ? m.icache : m.dcache;
    endfunction

endpackage

// File: rtl/mmu_maint_regs.sv
module mmu_maint_regs
    import mmu_maint_pkg::*;
#(
    parameter int OFS_W = 4,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_fire,
    input  logic [OFS_W-1:0] wr_offset,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] rd_offset,
    input  logic             err_set,
    input  logic             busy,
    output mode_t            mode,
    output logic             cmd_fire,
    output cmd_t             cmd,
    output logic [DW-1:0]    rd_data
);

    localparam logic [OFS_W-1:0] MODE_OFS   = OFS_W'(OFS_MODE);
    localparam logic [OFS_W-1:0] STATUS_OFS = OFS_W'(OFS_STATUS);
    localparam logic [OFS_W-1:0] CMD_GROUP  = OFS_W'(1);

    logic err_q;
    logic is_cmd;
    logic rd_status;

    assign is_cmd    = (wr_offset >> 3) == CMD_GROUP;
    assign cmd_fire  = wr_fire && is_cmd;
    assign cmd.side  = wr_offset[2];
    assign cmd.kind  = cmd_kind_e'(wr_offset[1:0]);
    assign rd_status = rd_en && (rd_offset == STATUS_OFS);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (wr_fire && wr_offset == MODE_OFS) begin
            mode <= mode_t'(wr_data[MODE_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (err_set) begin
            err_q <= 1'b1;
        end else if (rd_status) begin
            err_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (rd_offset == MODE_OFS) begin
                rd_data[MODE_W-1:0] = mode;
            end else if (rd_offset == STATUS_OFS) begin
                rd_data[1:0] = {busy, err_q};
            end
        end
    end

endmodule

// File: rtl/mmu_maint_seq.sv
module mmu_maint_seq
    import mmu_maint_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_t         mode,
    input  logic          cmd_fire,
    input  cmd_t          cmd,
    input  logic [AW-1:0] cmd_addr,
    input  logic          tlb_ack,
    input  logic [AW-1:0] tlb_paddr,
    input  logic          tlb_fault,
    input  logic          cache_ack,
    output seq_state_e    state,
    output cmd_t          cur,
    output logic [AW-1:0] cur_vaddr,
    output logic [AW-1:0] cur_paddr,
    output logic          err_set
);

    seq_state_e nxt;
    logic       xlate_ok;

    assign xlate_ok = (state == ST_TRANSLATE) && tlb_ack && !tlb_fault &&
                      (cur.kind != CMD_TLB_INV);
    assign err_set  = (state == ST_TRANSLATE) && tlb_ack && tlb_fault &&
                      (cur.kind != CMD_TLB_INV);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_fire) begin
                    if (cmd.kind == CMD_TLB_INV) begin
                        nxt = ST_TRANSLATE;
                    end else if (!cache_on(mode, cmd.side)) begin
                        nxt = ST_DONE;
                    end else if (cmd.kind == CMD_FLUSH) begin
                        nxt = ST_CACHE_OP;
                    end else if (tlb_on(mode, cmd.side)) begin
                        nxt = ST_TRANSLATE;
                    end else begin
                        nxt = ST_CACHE_OP;
                    end
                end
            end
            ST_TRANSLATE: begin
                if (tlb_ack) begin
                    nxt = xlate_ok ? ST_CACHE_OP : ST_DONE;
                end
            end
            ST_CACHE_OP: begin
                if (cache_ack) begin
                    nxt = ST_DONE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur       <= '0;
            cur_vaddr <= '0;
            cur_paddr <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && cmd_fire) begin
                cur       <= cmd;
                cur_vaddr <= cmd_addr;
                cur_paddr <= cmd_addr;
            end else if (xlate_ok) begin
                cur_paddr <= tlb_paddr;
            end
        end
    end

endmodule

// File: rtl/mmu_side_port.sv
module mmu_side_port
    import mmu_maint_pkg::*;
#(
    parameter int   AW   = 32,
    parameter logic SIDE = 1'b0
) (
    input  seq_state_e    state,
    input  cmd_t          cur,
    input  logic [AW-1:0] cur_vaddr,
    input  logic [AW-1:0] cur_paddr,
    output logic          tlb_req,
    output logic          tlb_op,
    output logic [AW-1:0] tlb_vaddr,
    output logic          cache_req,
    output logic [1:0]    cache_op,
    output logic [AW-1:0] cache_addr
);

    logic mine;

    assign mine       = (cur.side == SIDE);
    assign tlb_req    = mine && (state == ST_TRANSLATE);
    assign tlb_op     = (cur.kind == CMD_TLB_INV);
    assign tlb_vaddr  = mine ? cur_vaddr : '0;
    assign cache_req  = mine && (state == ST_CACHE_OP);
    assign cache_op   = mine ? 2'(cur.kind) : 2'b00;
    assign cache_addr = mine ? cur_paddr : '0;

endmodule

// File: rtl/mmu_maint_ctrl.sv
module mmu_maint_ctrl
    import mmu_maint_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFS_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_valid,
    output logic                wr_ready,
    input  logic [OFS_W-1:0]    wr_offset,
    input  logic [AW-1:0]       wr_data,
    input  logic                rd_en,
    input  logic [OFS_W-1:0]    rd_offset,
    output logic [AW-1:0]       rd_data,
    output logic [MODE_W-1:0]   mode_o,
    output logic                busy,
    output logic [1:0]          tlb_req,
    output logic [1:0]          tlb_op,
    output logic [2*AW-1:0]     tlb_vaddr,
    input  logic [1:0]          tlb_ack,
    input  logic [2*AW-1:0]     tlb_paddr,
    input  logic [1:0]          tlb_fault,
    output logic [1:0]          cache_req,
    output logic [3:0]          cache_op,
    output logic [2*AW-1:0]     cache_addr,
    input  logic [1:0]          cache_ack
);

    mode_t         mode;
    logic          wr_fire;
    logic          cmd_fire;
    cmd_t          cmd;
    logic          err_set;
    seq_state_e    state;
    cmd_t          cur;
    logic [AW-1:0] cur_vaddr;
    logic [AW-1:0] cur_paddr;

    assign wr_ready = (state == ST_IDLE);
    assign busy     = (state != ST_IDLE);
    assign wr_fire  = wr_valid && wr_ready;
    assign mode_o   = mode;

    mmu_maint_regs #(.OFS_W(OFS_W), .DW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_fire   (wr_fire),
        .wr_offset (wr_offset),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_offset (rd_offset),
        .err_set   (err_set),
        .busy      (busy),
        .mode      (mode),
        .cmd_fire  (cmd_fire),
        .cmd       (cmd),
        .rd_data   (rd_data)
    );

    mmu_maint_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .cmd_fire  (cmd_fire),
        .cmd       (cmd),
        .cmd_addr  (wr_data),
        .tlb_ack   (tlb_ack[cur.side]),
        .tlb_paddr (tlb_paddr[cur.side*AW +: AW]),
        .tlb_fault (tlb_fault[cur.side]),
        .cache_ack (cache_ack[cur.side]),
        .state     (state),
        .cur       (cur),
        .cur_vaddr (cur_vaddr),
        .cur_paddr (cur_paddr),
        .err_set   (err_set)
    );

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        mmu_side_port #(.AW(AW), .SIDE(1'(s))) u_port (
            .state      (state),
            .cur        (cur),
            .cur_vaddr  (cur_vaddr),
            .cur_paddr  (cur_paddr),
            .tlb_req    (tlb_req[s]),
            .tlb_op     (tlb_op[s]),
            .tlb_vaddr  (tlb_vaddr[s*AW +: AW]),
            .cache_req  (cache_req[s]),
            .cache_op   (cache_op[2*s +: 2]),
            .cache_addr (cache_addr[s*AW +: AW])
        );
    end

endmodule

// File: rtl/mmu_maint_ctrl_chk.sv
module mmu_maint_ctrl_chk #(
    parameter int AW    = 32,
    parameter int OFS_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [OFS_W-1:0] wr_offset,
    input logic [AW-1:0]    wr_data,
    input logic [3:0]       mode_o,
    input logic             busy,
    input logic [1:0]       tlb_req,
    input logic [1:0]       tlb_ack,
    input logic [1:0]       cache_req,
    input logic [1:0]       cache_ack
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mode_o == 4'd0 && !busy && wr_ready && tlb_req == 2'b00 && cache_req == 2'b00)); // R1

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && wr_offset == '0) |=> (mode_o == $past(wr_data[3:0]))); // R2

    AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wr_ready); // R10

    AST_MODE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_o)); // R10

    AST_TLB_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((tlb_req != 2'b00) && ((tlb_req & tlb_ack) == 2'b00)) |=> (tlb_req == $past(tlb_req))); // R10

    AST_CACHE_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((cache_req != 2'b00) && ((cache_req & cache_ack) == 2'b00)) |=> (cache_req == $past(cache_req))); // R10

    AST_RETIRE_BUSY: assert property (@(posedge clk) disable iff (rst)
        $fell(|cache_req) |-> busy); // R10

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tlb_req, cache_req})); // R11

endmodule

bind mmu_maint_ctrl mmu_maint_ctrl_chk #(.AW(AW), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_offset (wr_offset),
    .wr_data   (wr_data),
    .mode_o    (mode_o),
    .busy      (busy),
    .tlb_req   (tlb_req),
    .tlb_ack   (tlb_ack),
    .cache_req (cache_req),
    .cache_ack (cache_ack)
);

// File: tb/mmu_maint_ctrl_bench.sv
module mmu_maint_ctrl_bench;

    localparam int AW  = 32;
    localparam int LAT = 2;
    localparam logic [31:0] XMASK = 32'h5A00_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [3:0]    wr_offset = '0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [3:0]    rd_offset = '0;
    logic [31:0]   rd_data;
    logic [3:0]    mode_o;
    logic          busy;
    logic [1:0]    tlb_req, tlb_op, tlb_ack, tlb_fault;
    logic [63:0]   tlb_vaddr, tlb_paddr;
    logic [1:0]    cache_req, cache_ack;
    logic [3:0]    cache_op;
    logic [63:0]   cache_addr;

    always #2.5 clk = ~clk;

    mmu_maint_ctrl u_mmu_maint_ctrl (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_offset(wr_offset), .wr_data(wr_data), .rd_en(rd_en),
        .rd_offset(rd_offset), .rd_data(rd_data), .mode_o(mode_o), .busy(busy),
        .tlb_req(tlb_req), .tlb_op(tlb_op), .tlb_vaddr(tlb_vaddr),
        .tlb_ack(tlb_ack), .tlb_paddr(tlb_paddr), .tlb_fault(tlb_fault),
        .cache_req(cache_req), .cache_op(cache_op), .cache_addr(cache_addr),
        .cache_ack(cache_ack)
    );

    // Behavioural TLB and cache responders
    int tcnt [2];
    int ccnt [2];
    for (genvar s = 0; s < 2; s++) begin : g_resp
        assign tlb_paddr[s*32 +: 32] = tlb_vaddr[s*32 +: 32] ^ XMASK;
        assign tlb_fault[s]          = (tlb_vaddr[s*32+28 +: 4] == 4'hF);
        always @(posedge clk) begin
            if (rst || tlb_ack[s]) begin
                tlb_ack[s] <= 1'b0; tcnt[s] <= 0;
            end else if (tlb_req[s]) begin
                if (tcnt[s] == LAT) tlb_ack[s] <= 1'b1; else tcnt[s] <= tcnt[s] + 1;
            end
            if (rst || cache_ack[s]) begin
                cache_ack[s] <= 1'b0; ccnt[s] <= 0;
            end else if (cache_req[s]) begin
                if (ccnt[s] == LAT) cache_ack[s] <= 1'b1; else ccnt[s] <= ccnt[s] + 1;
            end
        end
    end

    // Reference model: 0 idle, 1 translate, 2 cache, 3 retire
    int          m_phase;
    logic        m_side;
    logic [1:0]  m_op;
    logic [31:0] m_vaddr, m_paddr;
    logic [3:0]  m_mode;

    always @(posedge clk) begin
        if (rst) begin
            m_phase <= 0; m_mode <= 4'd0; m_side <= 1'b0; m_op <= 2'd0;
            m_vaddr <= '0; m_paddr <= '0;
        end else begin
            case (m_phase)
                0: if (wr_valid) begin
                    if (wr_offset == 4'd0) m_mode <= wr_data[3:0];
                    else if (wr_offset[3]) begin
                        m_side <= wr_offset[2]; m_op <= wr_offset[1:0];
                        m_vaddr <= wr_data; m_paddr <= wr_data;
                        if (wr_offset[1:0] == 2'd0) m_phase <= 1;
                        else if (!(wr_offset[2] ? m_mode[1] : m_mode[0])) m_phase <= 3;
                        else if (wr_offset[1:0] == 2'd1) m_phase <= 2;
                        else if (wr_offset[2] ? m_mode[3] : m_mode[2]) m_phase <= 1;
                        else m_phase <= 2;
                    end
                end
                1: if (tlb_ack[m_side]) begin
                    if (m_op == 2'd0 || m_vaddr[31:28] == 4'hF) m_phase <= 3;
                    else begin m_paddr <= m_vaddr ^ XMASK; m_phase <= 2; end
                end
                2: if (cache_ack[m_side]) m_phase <= 3;
                default: m_phase <= 0;
            endcase
        end
    end

    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Request counters and per-cycle model comparison
    int   treqs [2];
    int   creqs [2];
    logic [1:0] prev_t = 2'b00, prev_c = 2'b00;
    logic [31:0] last_caddr [2];

    always @(negedge clk) begin
        if (!rst) begin
            for (int s = 0; s < 2; s++) begin
                if (tlb_req[s] && !prev_t[s]) treqs[s]++;
                if (cache_req[s] && !prev_c[s]) creqs[s]++;
                if (cache_req[s]) last_caddr[s] = cache_addr[s*32 +: 32];
            end
            prev_t = tlb_req; prev_c = cache_req;
            chk(busy == (m_phase != 0) && wr_ready == (m_phase == 0), "R10 busy/ready",
                {busy, wr_ready}, {m_phase != 0, m_phase == 0});
            chk(mode_o == m_mode, "R2 mode_o", mode_o, m_mode);
            chk(tlb_req == ((m_phase == 1) ? (2'b01 << m_side) : 2'b00) &&
                cache_req == ((m_phase == 2) ? (2'b01 << m_side) : 2'b00), "R11 requests",
                {tlb_req, cache_req}, {m_phase == 1, m_side, m_phase == 2});
            if (m_phase == 1)
                chk(tlb_op[m_side] == (m_op == 2'd0) && tlb_vaddr[m_side*32 +: 32] == m_vaddr,
                    "R5 tlb op/addr", {tlb_op[m_side], tlb_vaddr[m_side*32 +: 32]}, {m_op == 2'd0, m_vaddr});
            if (m_phase == 2)
                chk(cache_op[m_side*2 +: 2] == m_op && cache_addr[m_side*32 +: 32] == m_paddr,
                    "R6 cache op/addr", {cache_op[m_side*2 +: 2], cache_addr[m_side*32 +: 32]}, {m_op, m_paddr});
        end
    end

    int busy_cycles;

    task automatic do_wr(input logic [3:0] ofs, input logic [31:0] d);
        do @(negedge clk); while (!wr_ready);
        wr_valid = 1'b1; wr_offset = ofs; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        busy_cycles = 0;
        while (busy) begin busy_cycles++; @(negedge clk); end
    endtask

    task automatic do_rd(input logic [3:0] ofs, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_offset = ofs;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int t0, t1, c0, c1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(mode_o == 0 && !busy && wr_ready && tlb_req == 0 && cache_req == 0, "R1 reset",
            {mode_o, busy, wr_ready, tlb_req, cache_req}, {4'd0, 1'b0, 1'b1, 4'd0});
        do_rd(4'd1, v);
        chk(v == 0, "R1 status after reset", v, 0);

        // R2 enable word
        do_wr(4'd0, 32'hABCD_0005);
        do_rd(4'd0, v);
        chk(v == 32'h5, "R2 readback", v, 32'h5);
        do_wr(4'd0, 32'hFFFF_FFFF);
        do_rd(4'd0, v);
        chk(v == 32'hF, "R2 readback all on", v, 32'hF);

        // R3 command offsets read zero
        for (int o = 8; o < 16; o++) begin
            do_rd(4'(o), v);
            chk(v == 0, "R3 command readback", v, 0);
        end

        // R4 / R11 flush on each side
        t0 = treqs[0]; t1 = treqs[1]; c0 = creqs[0]; c1 = creqs[1];
        do_wr(4'd9, 32'hDEAD_BEEF);
        chk(creqs[0] == c0 + 1 && creqs[1] == c1 && treqs[0] == t0 && treqs[1] == t1,
            "R4 data flush", creqs[0] - c0, 1);
        do_wr(4'd13, 32'h0);
        chk(creqs[1] == c1 + 1 && creqs[0] == c0 + 1 && treqs[1] == t1,
            "R11 instruction flush side", creqs[1] - c1, 1);

        // R5 TLB invalidate, enabled and disabled
        t1 = treqs[1]; c1 = creqs[1];
        do_wr(4'd12, 32'h1234_5000);
        chk(treqs[1] == t1 + 1 && creqs[1] == c1, "R5 itlb invalidate", treqs[1] - t1, 1);
        do_wr(4'd0, 32'h0);
        t0 = treqs[0]; c0 = creqs[0];
        do_wr(4'd8, 32'h0000_7000);
        chk(treqs[0] == t0 + 1 && creqs[0] == c0, "R5 dtlb invalidate while off", treqs[0] - t0, 1);

        // R6 translate then cache op
        do_wr(4'd0, 32'hF);
        t0 = treqs[0]; c0 = creqs[0];
        do_wr(4'd10, 32'h0000_4440);
        chk(treqs[0] == t0 + 1 && creqs[0] == c0 + 1, "R6 data line inval steps", creqs[0] - c0, 1);
        chk(last_caddr[0] == (32'h0000_4440 ^ XMASK), "R6 translated addr", last_caddr[0], 32'h0000_4440 ^ XMASK);
        t1 = treqs[1]; c1 = creqs[1];
        do_wr(4'd15, 32'h0100_0080);
        chk(treqs[1] == t1 + 1 && last_caddr[1] == (32'h0100_0080 ^ XMASK), "R6 instr prefetch",
            last_caddr[1], 32'h0100_0080 ^ XMASK);

        // R7 data TLB off, data cache on
        do_wr(4'd0, 32'hB);
        t0 = treqs[0];
        do_wr(4'd11, 32'h0BAD_0040);
        chk(treqs[0] == t0 && last_caddr[0] == 32'h0BAD_0040, "R7 bypass translate",
            last_caddr[0], 32'h0BAD_0040);

        // R8 caches off
        do_wr(4'd0, 32'hC);
        t0 = treqs[0]; c0 = creqs[0];
        do_wr(4'd10, 32'h0000_1000);
        chk(treqs[0] == t0 && creqs[0] == c0 && busy_cycles == 1, "R8 line inval cache off",
            busy_cycles, 1);
        c1 = creqs[1];
        do_wr(4'd13, 32'h0);
        chk(creqs[1] == c1 && busy_cycles == 1, "R8 flush cache off", busy_cycles, 1);

        // R9 translation fault
        do_wr(4'd0, 32'hF);
        t0 = treqs[0]; c0 = creqs[0];
        do_wr(4'd10, 32'hF000_0100);
        chk(treqs[0] == t0 + 1 && creqs[0] == c0, "R9 cache step skipped", creqs[0] - c0, 0);
        do_rd(4'd1, v);
        chk(v == 32'h1, "R9 error flag set", v, 32'h1);
        do_rd(4'd1, v);
        chk(v == 32'h0, "R9 error flag cleared", v, 32'h0);

        // R10 write held off while busy
        c0 = creqs[0];
        @(negedge clk);
        wr_valid = 1'b1; wr_offset = 4'd10; wr_data = 32'h0000_0200;
        @(negedge clk);
        wr_offset = 4'd0; wr_data = 32'h3;
        chk(busy && mode_o == 4'hF, "R10 stalled mode write", mode_o, 4'hF);
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        chk(mode_o == 4'h3 && creqs[0] == c0 + 1, "R10 write after retire", mode_o, 4'h3);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule